// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits between a host and a parallel NOR flash that has been reduced to a simple synchronous bus. The host hands it one request at a time: program a word, erase a sector, or erase the whole array, together with a target address and, for a program, the word to store. The sequencer then emits the fixed unlock write preamble that the flash needs for that operation, one bus write per step, and finishes with the operation's final command write.

After the last write it keeps reading the target location until the flash reports that the internal operation has finished. Two completion methods can be chosen per request. In the toggle method, two reads in a row agree on bit 6. In the polling method, bit 7 of a read equals bit 7 of the expected final word. When completion is indicated but the word read back is not the expected final value, the block does not fail at once. It reads the location twice more and reports an error only if either of those reads is still wrong, because a status read can coincide with the moment the flash finishes. A parameterised poll limit bounds the wait. The outcome is a one-cycle done or error pulse.

Top module: `flseq_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and bus_wr, bus_rd, done and err are all 0.
- R2: A program request (req_op=00) emits four writes in order: 0x00AA at 0x5555, 0x0055 at 0x2AAA, 0x00A0 at 0x5555, then req_data at req_addr. Command writes drive bits 15:8 of bus_wdata to zero.
- R3: A sector erase (req_op=01) emits six writes: 0x00AA@0x5555, 0x0055@0x2AAA, 0x0080@0x5555, 0x00AA@0x5555, 0x0055@0x2AAA, then 0x0030 at the sector base. The sector base is req_addr with its low SECT_W (default 11) bits cleared.
- R4: A chip erase (req_op=10) emits the same first five writes as R3, and its sixth write is 0x0010 at 0x5555.
- R5: Each transfer holds bus_wr or bus_rd, with a stable address and write data, until a cycle in which bus_rdy is 1. Writes and reads never overlap, and each step issues exactly one transfer.
- R6: After the last write, reads go to the poll address: req_addr for program and chip erase, the sector base for sector erase. With req_mode=0 (toggle), completion is indicated when a read's bit 6 equals bit 6 of the previous read, and done pulses if that word equals the expected value.
- R7: With req_mode=1 (polling), completion is indicated when bit 7 of a read equals bit 7 of the expected word. The expected word is req_data for a program and 0xFFFF for an erase.
- R8: If completion is indicated but the word differs from the expected value, exactly two further reads are made. done pulses if both match; otherwise err pulses after the second read.
- R9: If MAX_POLLS reads pass without a completion indication, err pulses after the last of them and no further reads are made.
- R10: req_ready is 0 from acceptance until the done or err pulse. A request presented meanwhile is ignored and causes no bus transfer. When the pulse appears, req_ready is 1 and the bus is idle.
- R11: A request with req_op=11 produces an err pulse in the next cycle and no bus transfer.
- R12: done and err are single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 invalid |
| req_mode | input | 1 | 0 toggle-bit completion, 1 bit-7 polling completion |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| done | output | 1 | Operation completed pulse |
| err | output | 1 | Operation failed, timed out or invalid pulse |
| bus_wr | output | 1 | Bus write request |
| bus_rd | output | 1 | Bus read request |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with bus_rdy |
| bus_rdy | input | 1 | Current transfer completes this cycle |

## Verification
The assertions take for granted that bus_rdy is raised only while bus_wr or bus_rd is 1, and that bus_rdata is valid in the cycle it is raised. They also assume the request fields are sampled only while req_ready is 1. The bench's flash model keeps within these rules. It answers each transfer after a programmable number of wait cycles and returns a scripted sequence of read words. That script is what makes bit 6 toggle or stop, what holds bit 7 inverted, and what produces a race read followed by good or bad confirmation reads.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_BAD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_POLL = 2'd2,
        ST_CONF = 2'd3
    } st_e;

    localparam logic [31:0] UNLOCK_ADR_A = 32'h0000_5555;
    localparam logic [31:0] UNLOCK_ADR_B = 32'h0000_2AAA;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_WORD  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
endpackage

// File: rtl/flseq_step_gen.sv
module flseq_step_gen
    import flseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int SECT_W = 11
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] taddr,
    input  logic [DW-1:0] tdata,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          last,
    output logic [AW-1:0] paddr
);
    localparam logic [AW-1:0] ADR_A    = UNLOCK_ADR_A[AW-1:0];
    localparam logic [AW-1:0] ADR_B    = UNLOCK_ADR_B[AW-1:0];
    localparam logic [AW-1:0] OFS_MASK = AW'((64'd1 << SECT_W) - 64'd1);

    logic [7:0]    code;
    logic          use_data;
    logic [AW-1:0] sect_base;

    assign sect_base = taddr & ~OFS_MASK;
    assign paddr     = (op == OP_SECT) ? sect_base : taddr;

    always_comb begin
        code     = CODE_KEY1;
        waddr    = ADR_A;
        use_data = 1'b0;
        last     = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0: begin code = CODE_KEY1; waddr = ADR_A; end
                3'd1: begin code = CODE_KEY2; waddr = ADR_B; end
                3'd2: begin code = CODE_WORD; waddr = ADR_A; end
                default: begin
                    use_data = 1'b1;
                    waddr    = taddr;
                    last     = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin code = CODE_KEY1;  waddr = ADR_A; end
                3'd1: begin code = CODE_KEY2;  waddr = ADR_B; end
                3'd2: begin code = CODE_ERASE; waddr = ADR_A; end
                3'd3: begin code = CODE_KEY1;  waddr = ADR_A; end
                3'd4: begin code = CODE_KEY2;  waddr = ADR_B; end
                default: begin
                    last = 1'b1;
                    if (op == OP_CHIP) begin
                        code  = CODE_CHIP;
                        waddr = ADR_A;
                    end else begin
                        code  = CODE_SECT;
                        waddr = sect_base;
                    end
                end
            endcase
        end
        wdata = use_data ? tdata : {{(DW-8){1'b0}}, code};
    end
endmodule

// File: rtl/flseq_done_det.sv
module flseq_done_det #(
    parameter int DW = 16
) (
    input  logic          mode,
    input  logic          have_prev,
    input  logic          prev6,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] expect_w,
    output logic          seen,
    output logic          match
);
    logic tgl_seen;
    logic pol_seen;

    assign tgl_seen = have_prev && (rdata[6] == prev6);
    assign pol_seen = (rdata[7] == expect_w[7]);
    assign seen     = mode ? pol_seen : tgl_seen;
    assign match    = (rdata == expect_w);
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
    import flseq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int SECT_W     = 11,
    parameter int MAX_POLLS  = 1000,
    parameter int CONF_READS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          done,
    output logic          err,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int CW = $clog2(CONF_READS + 1);

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic          mode;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [2:0]    step;
        logic [PW-1:0] pcnt;
        logic [CW-1:0] ccnt;
        logic          cbad;
        logic          have_prev;
        logic          prev6;
        logic          done;
        logic          err;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0] step_addr;
    logic [DW-1:0] step_data;
    logic          step_last;
    logic [AW-1:0] poll_addr;
    logic [DW-1:0] expect_w;
    logic          seen;
    logic          match;
    logic          conf_bad;

    flseq_step_gen #(.AW(AW), .DW(DW), .SECT_W(SECT_W)) u_step (
        .op    (q.op),
        .step  (q.step),
        .taddr (q.addr),
        .tdata (q.data),
        .waddr (step_addr),
        .wdata (step_data),
        .last  (step_last),
        .paddr (poll_addr)
    );

    assign expect_w = (q.op == OP_PROG) ? q.data : {DW{1'b1}};

    flseq_done_det #(.DW(DW)) u_det (
        .mode      (q.mode),
        .have_prev (q.have_prev),
        .prev6     (q.prev6),
        .rdata     (bus_rdata),
        .expect_w  (expect_w),
        .seen      (seen),
        .match     (match)
    );

    assign conf_bad = q.cbad | ~match;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op        = op_e'(req_op);
                    d.mode      = req_mode;
                    d.addr      = req_addr;
                    d.data      = req_data;
                    d.step      = 3'd0;
                    d.pcnt      = '0;
                    d.ccnt      = '0;
                    d.cbad      = 1'b0;
                    d.have_prev = 1'b0;
                    d.prev6     = 1'b0;
                    if (op_e'(req_op) == OP_BAD) begin
                        d.err = 1'b1;
                    end else begin
                        d.st = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (bus_rdy) begin
                    if (step_last) begin
                        d.st = ST_POLL;
                    end else begin
                        d.step = q.step + 3'd1;
                    end
                end
            end
            ST_POLL: begin
                if (bus_rdy) begin
                    d.pcnt = q.pcnt + 1'b1;
                    if (seen) begin
                        if (match) begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = ST_CONF;
                        end
                    end else if (q.pcnt == PW'(MAX_POLLS - 1)) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.have_prev = 1'b1;
                        d.prev6     = bus_rdata[6];
                    end
                end
            end
            default: begin
                if (bus_rdy) begin
                    d.ccnt = q.ccnt + 1'b1;
                    d.cbad = conf_bad;
                    if (q.ccnt == CW'(CONF_READS - 1)) begin
                        d.st   = ST_IDLE;
                        d.err  = conf_bad;
                        d.done = ~conf_bad;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign bus_wr    = (q.st == ST_CMD);
    assign bus_rd    = (q.st == ST_POLL) || (q.st == ST_CONF);
    assign bus_addr  = (q.st == ST_CMD) ? step_addr : poll_addr;
    assign bus_wdata = (q.st == ST_CMD) ? step_data : '0;
endmodule

// File: rtl/flseq_ctrl_chk.sv
module flseq_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          req_ready,
    input logic          done,
    input logic          err,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rdy
);
    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !bus_rdy |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R5
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_rdy |=> bus_rd && $stable(bus_addr)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> !req_ready); // R10
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> req_ready && !bus_wr && !bus_rd); // R10
    AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && req_op != 2'b11 |=>
        bus_wr && bus_addr == AW'(16'h5555) && bus_wdata == DW'(16'h00AA)); // R2
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && req_op == 2'b11 |=> err && !bus_wr && !bus_rd); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
endmodule

bind flseq_ctrl flseq_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdy   (bus_rdy)
);

// File: tb/tb_flseq_ctrl.sv
module tb_flseq_ctrl;
    localparam int MAXP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_mode = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_ready, done, err, bus_wr, bus_rd, bus_rdy;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;

    int nchk = 0;
    int nerr = 0;

    logic [15:0] rd_seq [64];
    int seq_len = 1;
    int lat = 0;
    int wcnt = 0;
    int wn = 0;
    int rn = 0;
    int wn0 = 0;
    int rn0 = 0;
    logic [15:0] wa [256];
    logic [15:0] wd [256];
    logic [15:0] ra [256];

    always #10 clk = ~clk;

    flseq_ctrl #(.AW(16), .DW(16), .SECT_W(11), .MAX_POLLS(MAXP), .CONF_READS(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .done(done), .err(err), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    assign bus_rdy = (bus_wr || bus_rd) && (wcnt == lat);

    always_comb begin
        int idx;
        idx = rn - rn0;
        if (idx >= seq_len) idx = seq_len - 1;
        if (idx < 0) idx = 0;
        bus_rdata = rd_seq[idx];
    end

    always @(posedge clk) begin
        if (bus_wr || bus_rd) begin
            if (bus_rdy) begin
                wcnt <= 0;
                if (bus_wr) begin
                    wa[wn & 255] <= bus_addr;
                    wd[wn & 255] <= bus_wdata;
                    wn <= wn + 1;
                end else begin
                    ra[rn & 255] <= bus_addr;
                    rn <= rn + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic clear_seq();
        for (int i = 0; i < 64; i++) rd_seq[i] = 16'h0000;
    endtask

    task automatic issue(input logic [1:0] op, input logic mode,
                         input logic [15:0] a, input logic [15:0] dt);
        @(negedge clk);
        wn0 = wn;
        rn0 = rn;
        req_op = op; req_mode = mode; req_addr = a; req_data = dt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        int k;
        k = 0;
        while (!(done || err) && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic chk_wr(input string r, input int k, input logic [15:0] a, input logic [15:0] dt);
        chk(r, {16'h0, wa[(wn0 + k) & 255]}, {16'h0, a});
        chk(r, {16'h0, wd[(wn0 + k) & 255]}, {16'h0, dt});
    endtask

    task automatic chk_pulse(input string r);
        @(negedge clk);
        chk(r, {30'h0, done, err}, 32'h0);
        chk(r, {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_reset();
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 bus idle", {30'h0, bus_wr, bus_rd}, 32'h0);
        chk("R1 flags", {30'h0, done, err}, 32'h0);
    endtask

    task automatic t_prog_toggle();
        lat = 0;
        clear_seq();
        rd_seq[0] = 16'h0040; rd_seq[1] = 16'h0000; rd_seq[2] = 16'h0040; rd_seq[3] = 16'hBEEF;
        seq_len = 4;
        issue(2'b00, 1'b0, 16'h1234, 16'hBEEF);
        wait_end();
        chk("R6 done", {30'h0, done, err}, 32'h2);
        chk("R2 write count", wn - wn0, 4);
        chk_wr("R2 unlock1", 0, 16'h5555, 16'h00AA);
        chk_wr("R2 unlock2", 1, 16'h2AAA, 16'h0055);
        chk_wr("R2 cmd", 2, 16'h5555, 16'h00A0);
        chk_wr("R2 word", 3, 16'h1234, 16'hBEEF);
        chk("R6 reads", rn - rn0, 4);
        chk("R6 poll addr", {16'h0, ra[(rn - 1) & 255]}, 32'h1234);
        chk_pulse("R12 pulse prog");
    endtask

    task automatic t_prog_poll_busy();
        lat = 2;
        clear_seq();
        rd_seq[0] = 16'h0080; rd_seq[1] = 16'h0080; rd_seq[2] = 16'h1234;
        seq_len = 3;
        issue(2'b00, 1'b1, 16'h0042, 16'h1234);
        req_op = 2'b10; req_addr = 16'h0100; req_valid = 1'b1;
        chk("R10 busy", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_end();
        chk("R7 done", {30'h0, done, err}, 32'h2);
        chk("R10 no extra", wn - wn0, 4);
        chk("R5 word after wait", {16'h0, wd[(wn0 + 3) & 255]}, 32'h1234);
        chk("R7 reads", rn - rn0, 3);
        chk("R10 ready at end", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        chk("R10 bus idle after", {30'h0, bus_wr, bus_rd}, 32'h0);
        lat = 0;
    endtask

    task automatic t_sect_toggle();
        clear_seq();
        rd_seq[0] = 16'h0000; rd_seq[1] = 16'h0040; rd_seq[2] = 16'hFFFF;
        seq_len = 3;
        issue(2'b01, 1'b0, 16'hABCD, 16'h0000);
        wait_end();
        chk("R3 done", {30'h0, done, err}, 32'h2);
        chk("R3 write count", wn - wn0, 6);
        chk_wr("R3 s0", 0, 16'h5555, 16'h00AA);
        chk_wr("R3 s1", 1, 16'h2AAA, 16'h0055);
        chk_wr("R3 s2", 2, 16'h5555, 16'h0080);
        chk_wr("R3 s3", 3, 16'h5555, 16'h00AA);
        chk_wr("R3 s4", 4, 16'h2AAA, 16'h0055);
        chk_wr("R3 sector", 5, 16'hA800, 16'h0030);
        chk("R6 sector poll addr", {16'h0, ra[(rn - 1) & 255]}, 32'hA800);
        chk("R6 reads", rn - rn0, 3);
    endtask

    task automatic t_chip_poll();
        clear_seq();
        rd_seq[0] = 16'h0000; rd_seq[1] = 16'h0000; rd_seq[2] = 16'hFFFF;
        seq_len = 3;
        issue(2'b10, 1'b1, 16'h0777, 16'h0000);
        wait_end();
        chk("R4 done", {30'h0, done, err}, 32'h2);
        chk("R4 write count", wn - wn0, 6);
        chk_wr("R4 s2", 2, 16'h5555, 16'h0080);
        chk_wr("R4 last", 5, 16'h5555, 16'h0010);
        chk("R7 erase reads", rn - rn0, 3);
        chk("R6 chip poll addr", {16'h0, ra[(rn - 1) & 255]}, 32'h0777);
    endtask

    task automatic t_confirm_pass();
        clear_seq();
        rd_seq[0] = 16'h0000; rd_seq[1] = 16'h0080; rd_seq[2] = 16'h00F0; rd_seq[3] = 16'h00F0;
        seq_len = 4;
        issue(2'b00, 1'b1, 16'h0010, 16'h00F0);
        wait_end();
        chk("R8 confirm pass", {30'h0, done, err}, 32'h2);
        chk("R8 confirm reads", rn - rn0, 4);
    endtask

    task automatic t_confirm_fail();
        clear_seq();
        rd_seq[0] = 16'h0080; rd_seq[1] = 16'h0081; rd_seq[2] = 16'h00F0;
        seq_len = 3;
        issue(2'b00, 1'b1, 16'h0011, 16'h00F0);
        wait_end();
        chk("R8 confirm fail", {30'h0, done, err}, 32'h1);
        chk("R8 both rereads", rn - rn0, 3);
        chk_pulse("R12 pulse err");
    endtask

    task automatic t_timeout();
        clear_seq();
        for (int i = 0; i < 40; i++) rd_seq[i] = (i % 2 == 0) ? 16'h0040 : 16'h0000;
        seq_len = 40;
        issue(2'b00, 1'b0, 16'h0020, 16'h5A5A);
        wait_end();
        chk("R9 timeout err", {30'h0, done, err}, 32'h1);
        chk("R9 poll count", rn - rn0, MAXP);
        @(negedge clk);
        @(negedge clk);
        chk("R9 no more reads", rn - rn0, MAXP);
    endtask

    task automatic t_bad_op();
        issue(2'b11, 1'b0, 16'h0001, 16'h0001);
        chk("R11 err", {30'h0, done, err}, 32'h1);
        chk("R11 no writes", wn - wn0, 0);
        chk("R11 no reads", rn - rn0, 0);
        chk("R11 ready", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        chk("R12 err single", {31'h0, err}, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        clear_seq();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_toggle();
        t_prog_poll_busy();
        t_sect_toggle();
        t_chip_poll();
        t_confirm_pass();
        t_confirm_fail();
        t_timeout();
        t_bad_op();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule